// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a serial memory on a two-wire bus. It runs on a fast system clock and oversamples the SCL and SDA lines. It recognises START and STOP conditions. After each START it takes a device-select byte and checks it against two strap inputs. It then collects a 17-bit memory address: the top bit comes from the select byte and two further bytes follow. The block answers every byte with ACK or NACK through an active-high pull-down enable for SDA.

On the memory side it talks to a page-write controller over a plain parallel interface. Each accepted write byte is presented as a one-cycle strobe with its address and data. A second strobe marks the STOP that closes a write, which is when the controller starts its internal write cycle. Reads go out as a request strobe with an address, and the answering byte is taken from `rd_data` before it is shifted out.

The controller supplies a busy flag. While it is set, the block refuses its own select byte, so a master can poll until the write has finished. A write-protect input is latched once per write, just before the first data byte.

Top module: `twi_mem_slave`

## Requirements
- R1: A STOP (SDA rising while SCL is high) ends any transaction. Within one cycle of detection the engine is idle and SDA is released.
- R2: The select byte is taken MSB first as device code 1010, A2, A1, a16, R/W. It is acknowledged only when the code is 1010 and A2/A1 equal `strap[1]`/`strap[0]`. Otherwise it gets a NACK and everything up to the next START is ignored.
- R3: While `busy` is high when the select byte completes, that byte gets a NACK.
- R4: The address is a16 (select bit 1), then the high byte (bits 15..8), then the low byte (bits 7..0). Both address bytes are acknowledged.
- R5: Each accepted write data byte is acknowledged. It is also presented on `wr_valid` with `wr_addr` and `wr_data`. After each byte only the low 8 address bits advance, wrapping within the 256-byte page.
- R6: `wr_commit` pulses once for a STOP that ends a write in which at least one data byte was accepted, and for no other STOP.
- R7: `wp` is latched on the SCL falling edge that ends the low-address acknowledge. If it is high, the first data byte gets a NACK, no `wr_valid` is issued and no commit follows. A later change of `wp` has no effect on that write.
- R8: A read issues `rd_req` with `rd_addr` and shifts `rd_data` out MSB first, changing SDA only after SCL falls. SDA is released in the 9th clock. A master ACK advances the address by one modulo 2^17 and sends the next byte. A master NACK stops the driving.
- R9: A repeated START at any point restarts at the select byte. A write select plus address followed by a repeated START and a read select forms a random read.
- R10: The pull-down enable changes only after a detected SCL falling edge, a START or a STOP. It never changes while SCL is high.
- R11: Before the first START, all SCL/SDA activity is ignored and SDA is never pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level (wired-AND bus) |
| sda_pull | output | 1 | High pulls SDA low |
| strap | input | 2 | Address straps: bit 1 = A2, bit 0 = A1 |
| busy | input | 1 | Internal write cycle in progress |
| wp | input | 1 | Write protect, high blocks writes |
| wr_valid | output | 1 | One-cycle strobe for an accepted write byte |
| wr_addr | output | 17 | Address of the accepted write byte |
| wr_data | output | 8 | Accepted write byte |
| wr_commit | output | 1 | One-cycle strobe: STOP closed a valid write |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 17 | Address of the requested read byte |
| rd_data | input | 8 | Read byte, valid from the cycle after `rd_req` |

## Verification
The select decode is swept over all sixteen pairs of strap setting and select-byte bits, plus a byte with a wrong device code. This separates a correct strap compare from one that is swapped or ignored. A write that starts two bytes before the end of a page shows whether the address wraps inside the page or carries into the page number. A random read that starts two bytes below the top of the 17-bit space shows whether a16 is loaded from the select byte and whether the read counter wraps over all 17 bits. Two write-protect runs set `wp` before and after the sampling edge, which shows that the latch is taken at exactly one SCL edge. A busy run and clocking done before any START check the conditions under which the block must stay silent.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  localparam int MEM_AW   = 17;
  localparam int BYTE_W   = 8;
  localparam int HI_LSB   = 8;
  localparam int TOP_BIT  = MEM_AW - 1;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEL  = 3'd1,
    ST_AHI  = 3'd2,
    ST_ALO  = 3'd3,
    ST_WDAT = 3'd4,
    ST_RDAT = 3'd5
  } phase_t;

  // select byte layout: [7:4] code, [3] A2, [2] A1, [1] a16, [0] R/W
  function automatic logic sel_match(input logic [7:0] b,
                                     input logic [1:0] strap,
                                     input logic [3:0] code);
    sel_match = (b[7:4] == code) && (b[3:2] == strap);
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_d;
  logic              sda_d;
  logic              scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twi_mem_ctrl.sv
module twi_mem_ctrl
  import twi_mem_pkg::*;
#(
  parameter int         PW       = 8,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [1:0]        strap,
  input  logic              busy,
  input  logic              wp,
  input  logic [7:0]        rd_data,
  output logic              sda_pull,
  output logic              wr_valid,
  output logic [MEM_AW-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic              rd_req,
  output logic [MEM_AW-1:0] rd_addr,
  output phase_t            phase,
  output logic              sel_decide
);

  localparam logic [3:0] BIT_ACK  = 4'd8;
  localparam logic [3:0] BIT_DONE = 4'd9;

  phase_t            phase_q;
  logic [3:0]        bcnt_q;
  logic [7:0]        shreg_q;
  logic [MEM_AW-1:0] addr_q;
  logic              pull_q, ack_q, rnw_q, mack_q, wp_lat_q, wr_any_q;
  logic              wr_valid_q, wr_commit_q, rd_req_q;
  logic [MEM_AW-1:0] wr_addr_q;
  logic [7:0]        wr_data_q;
  logic              sel_ok;

  function automatic logic [MEM_AW-1:0] wr_next(input logic [MEM_AW-1:0] a);
    wr_next = {a[MEM_AW-1:PW], a[PW-1:0] + PW'(1)};
  endfunction

  function automatic logic [MEM_AW-1:0] rd_next(input logic [MEM_AW-1:0] a);
    rd_next = a + MEM_AW'(1);
  endfunction

  assign sel_ok     = sel_match(shreg_q, strap, DEV_CODE) && !busy;
  assign sel_decide = (phase_q == ST_SEL) && scl_fall && (bcnt_q == BIT_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= ST_IDLE;
      bcnt_q      <= '0;
      shreg_q     <= '0;
      addr_q      <= '0;
      pull_q      <= 1'b0;
      ack_q       <= 1'b0;
      rnw_q       <= 1'b0;
      mack_q      <= 1'b0;
      wp_lat_q    <= 1'b0;
      wr_any_q    <= 1'b0;
      wr_valid_q  <= 1'b0;
      wr_commit_q <= 1'b0;
      rd_req_q    <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      wr_valid_q  <= 1'b0;
      wr_commit_q <= 1'b0;
      rd_req_q    <= 1'b0;
      if (start_evt) begin
        phase_q  <= ST_SEL;
        bcnt_q   <= '0;
        pull_q   <= 1'b0;
        wr_any_q <= 1'b0;
      end else if (stop_evt) begin
        if (phase_q == ST_WDAT && wr_any_q) wr_commit_q <= 1'b1;
        phase_q  <= ST_IDLE;
        pull_q   <= 1'b0;
        wr_any_q <= 1'b0;
      end else if (phase_q != ST_IDLE) begin
        if (scl_rise) begin
          if (bcnt_q < BIT_ACK) begin
            bcnt_q <= bcnt_q + 4'd1;
            if (phase_q != ST_RDAT) shreg_q <= {shreg_q[6:0], sda_s};
          end else if (bcnt_q == BIT_ACK) begin
            bcnt_q <= BIT_DONE;
            if (phase_q == ST_RDAT) begin
              mack_q <= ~sda_s;
              if (!sda_s) begin
                addr_q   <= rd_next(addr_q);
                rd_req_q <= 1'b1;
              end
            end
          end
        end else if (scl_fall) begin
          if (bcnt_q == BIT_ACK) begin
            unique case (phase_q)
              ST_SEL: begin
                ack_q  <= sel_ok;
                pull_q <= sel_ok;
                rnw_q  <= shreg_q[0];
                if (sel_ok) begin
                  addr_q[TOP_BIT] <= shreg_q[1];
                  if (shreg_q[0]) rd_req_q <= 1'b1;
                end
              end
              ST_AHI: begin
                ack_q  <= 1'b1;
                pull_q <= 1'b1;
                addr_q[HI_LSB +: BYTE_W] <= shreg_q;
              end
              ST_ALO: begin
                ack_q  <= 1'b1;
                pull_q <= 1'b1;
                addr_q[BYTE_W-1:0] <= shreg_q;
              end
              ST_WDAT: begin
                ack_q  <= ~wp_lat_q;
                pull_q <= ~wp_lat_q;
                if (!wp_lat_q) begin
                  wr_valid_q <= 1'b1;
                  wr_addr_q  <= addr_q;
                  wr_data_q  <= shreg_q;
                  addr_q     <= wr_next(addr_q);
                  wr_any_q   <= 1'b1;
                end
              end
              default: pull_q <= 1'b0;
            endcase
          end else if (bcnt_q == BIT_DONE) begin
            bcnt_q <= '0;
            pull_q <= 1'b0;
            unique case (phase_q)
              ST_SEL: begin
                if (!ack_q) begin
                  phase_q <= ST_IDLE;
                end else if (rnw_q) begin
                  phase_q <= ST_RDAT;
                  shreg_q <= rd_data;
                  pull_q  <= ~rd_data[7];
                end else begin
                  phase_q <= ST_AHI;
                end
              end
              ST_AHI: phase_q <= ST_ALO;
              ST_ALO: begin
                phase_q  <= ST_WDAT;
                wp_lat_q <= wp;
              end
              ST_WDAT: if (!ack_q) phase_q <= ST_IDLE;
              ST_RDAT: begin
                if (mack_q) begin
                  shreg_q <= rd_data;
                  pull_q  <= ~rd_data[7];
                end else begin
                  phase_q <= ST_IDLE;
                end
              end
              default: phase_q <= ST_IDLE;
            endcase
          end else if (phase_q == ST_RDAT && bcnt_q != 4'd0) begin
            pull_q <= ~shreg_q[3'(4'd7 - bcnt_q)];
          end
        end
      end
    end
  end

  assign sda_pull  = pull_q;
  assign wr_valid  = wr_valid_q;
  assign wr_addr   = wr_addr_q;
  assign wr_data   = wr_data_q;
  assign wr_commit = wr_commit_q;
  assign rd_req    = rd_req_q;
  assign rd_addr   = addr_q;
  assign phase     = phase_q;

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         PAGE_BITS   = 8,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_pull,
  input  logic [1:0]  strap,
  input  logic        busy,
  input  logic        wp,
  output logic        wr_valid,
  output logic [16:0] wr_addr,
  output logic [7:0]  wr_data,
  output logic        wr_commit,
  output logic        rd_req,
  output logic [16:0] rd_addr,
  input  logic [7:0]  rd_data
);

  logic   sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic   sel_decide;
  phase_t phase;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  twi_mem_ctrl #(.PW(PAGE_BITS), .DEV_CODE(DEV_CODE)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .sda_s      (sda_s),
    .strap      (strap),
    .busy       (busy),
    .wp         (wp),
    .rd_data    (rd_data),
    .sda_pull   (sda_pull),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_commit  (wr_commit),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .phase      (phase),
    .sel_decide (sel_decide)
  );

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
  import twi_mem_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   sda_pull,
  input logic   scl_fall,
  input logic   start_evt,
  input logic   stop_evt,
  input logic   sel_decide,
  input logic   busy,
  input logic   wr_valid,
  input logic   wr_commit,
  input logic   rd_req,
  input phase_t phase
);

  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_pull && phase == ST_IDLE));

  p_busy_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_decide && busy) |=> !sda_pull);

  p_commit_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_evt));

  p_req_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_req));

  p_restart_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (phase == ST_SEL));

  p_pull_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall || start_evt || stop_evt));

  p_idle_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_IDLE) |-> !sda_pull);

endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sda_pull   (sda_pull),
  .scl_fall   (scl_fall),
  .start_evt  (start_evt),
  .stop_evt   (stop_evt),
  .sel_decide (sel_decide),
  .busy       (busy),
  .wr_valid   (wr_valid),
  .wr_commit  (wr_commit),
  .rd_req     (rd_req),
  .phase      (phase)
);

// File: tb/tb_twi_mem_slave.sv
`timescale 1ns/1ps
module tb_twi_mem_slave;

  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic [1:0]  strap = 2'b00;
  logic        busy = 1'b0;
  logic        wp = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic        sda_pull, wr_valid, wr_commit, rd_req;
  logic [16:0] wr_addr, rd_addr;
  logic [7:0]  wr_data;
  wire         sda_bus = m_sda & ~sda_pull;

  int n_cmp = 0;
  int n_bad = 0;
  int cap_n = 0;
  int commit_n = 0;
  int pull_n = 0;
  int hi_change_n = 0;
  logic        pull_prev = 1'b0;
  logic [16:0] cap_addr [0:15];
  logic [7:0]  cap_data [0:15];

  always #2.5 clk = ~clk;

  twi_mem_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .sda_pull(sda_pull), .strap(strap), .busy(busy), .wp(wp),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  function automatic logic [7:0] mem_val(input logic [16:0] a);
    mem_val = a[7:0] ^ a[15:8] ^ {a[16], 7'b0101101};
  endfunction

  function automatic logic [7:0] sel_byte(input logic [1:0] s, input logic a16,
                                          input logic rnw);
    sel_byte = {4'b1010, s, a16, rnw};
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= mem_val(rd_addr);

  always @(negedge clk) begin
    if (wr_valid && cap_n < 16) begin
      cap_addr[cap_n] = wr_addr;
      cap_data[cap_n] = wr_data;
      cap_n++;
    end
    if (wr_commit) commit_n++;
    if (sda_pull) pull_n++;
    if (sda_pull != pull_prev && m_scl) hi_change_n++;
    pull_prev = sda_pull;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q/2);
    acked = ~sda_bus; tick(Q/2);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      m_scl = 1'b1; tick(Q/2);
      d[i] = sda_bus; tick(Q/2);
      m_scl = 1'b0;
    end
    tick(Q);
    m_sda = ~mack; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic       ack;
    logic [7:0] d;
    int         base_cap, base_commit;
    logic [16:0] a;

    tick(5);
    rst_n = 1'b1;
    tick(3);
    check(sda_pull == 1'b0, "R11 reset pull", int'(sda_pull), 0);
    check(wr_valid == 1'b0 && rd_req == 1'b0, "R11 reset strobes", int'({wr_valid, rd_req}), 0);

    // R11: clocked traffic with no START first
    strap = 2'b01;
    m_scl = 1'b0; tick(Q);
    send_byte(sel_byte(2'b01, 1'b0, 1'b0), ack);
    check(ack == 1'b0, "R11 select before START", int'(ack), 0);
    check(pull_n == 0, "R11 no pull before START", pull_n, 0);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);

    // R2: strap versus select bits sweep
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int b = 0; b < 4; b++) begin
        bus_start();
        send_byte(sel_byte(2'(b), 1'b0, 1'b0), ack);
        check(ack == (s == b), "R2 strap match", int'(ack), int'(s == b));
        bus_stop();
        check(sda_pull == 1'b0, "R1 released after stop", int'(sda_pull), 0);
      end
    end
    strap = 2'b10;
    bus_start();
    send_byte(8'hB4, ack);
    check(ack == 1'b0, "R2 wrong device code", int'(ack), 0);
    bus_stop();
    check(commit_n == 0, "R6 no commit without data", commit_n, 0);

    // R4/R5/R6: write across a page end
    bus_start();
    send_byte(sel_byte(2'b10, 1'b1, 1'b0), ack);
    check(ack, "R2 select write", int'(ack), 1);
    send_byte(8'h34, ack);
    check(ack, "R4 high address ack", int'(ack), 1);
    send_byte(8'hFE, ack);
    check(ack, "R4 low address ack", int'(ack), 1);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'(8'h3C + 17 * k), ack);
      check(ack, "R5 data ack", int'(ack), 1);
    end
    bus_stop();
    tick(2);
    check(cap_n == 4, "R5 byte count", cap_n, 4);
    for (int k = 0; k < 4; k++) begin
      a = {1'b1, 8'h34, 8'(8'hFE + k)};
      check(cap_addr[k] == a, "R5 page wrap address", int'(cap_addr[k]), int'(a));
      check(cap_data[k] == 8'(8'h3C + 17 * k), "R5 data", int'(cap_data[k]), int'(8'(8'h3C + 17 * k)));
    end
    check(commit_n == 1, "R6 commit on stop", commit_n, 1);

    // R9/R8: random read across the top of the address space
    bus_start();
    send_byte(sel_byte(2'b10, 1'b1, 1'b0), ack);
    send_byte(8'hFF, ack);
    send_byte(8'hFE, ack);
    bus_start();
    send_byte(sel_byte(2'b10, 1'b1, 1'b1), ack);
    check(ack, "R9 read select after restart", int'(ack), 1);
    for (int k = 0; k < 3; k++) begin
      a = 17'h1FFFE + 17'(k);
      recv_byte(k < 2, d);
      check(d == mem_val(a), "R8 read data", int'(d), int'(mem_val(a)));
    end
    check(sda_pull == 1'b0, "R8 released after master NACK", int'(sda_pull), 0);
    bus_stop();
    tick(2);
    check(commit_n == 1, "R6 no commit after read", commit_n, 1);
    check(cap_n == 4, "R9 dummy write stores nothing", cap_n, 4);

    // R3: busy refuses select, then accepted once clear
    busy = 1'b1;
    bus_start();
    send_byte(sel_byte(2'b10, 1'b0, 1'b1), ack);
    check(ack == 1'b0, "R3 busy NACK", int'(ack), 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(sel_byte(2'b10, 1'b0, 1'b0), ack);
    check(ack, "R3 ready ACK", int'(ack), 1);
    bus_stop();

    // R7: protected write is rejected
    base_cap = cap_n; base_commit = commit_n;
    wp = 1'b1;
    bus_start();
    send_byte(sel_byte(2'b10, 1'b0, 1'b0), ack);
    send_byte(8'h12, ack);
    send_byte(8'h40, ack);
    send_byte(8'hA5, ack);
    check(ack == 1'b0, "R7 protected data NACK", int'(ack), 0);
    bus_stop();
    tick(2);
    check(cap_n == base_cap, "R7 no write strobe", cap_n, base_cap);
    check(commit_n == base_commit, "R7 no commit", commit_n, base_commit);

    // R7: wp raised after the sampling edge has no effect
    wp = 1'b0;
    bus_start();
    send_byte(sel_byte(2'b10, 1'b0, 1'b0), ack);
    send_byte(8'h12, ack);
    send_byte(8'h40, ack);
    send_byte(8'h5A, ack);
    check(ack, "R7 unprotected first byte", int'(ack), 1);
    wp = 1'b1;
    send_byte(8'h6B, ack);
    check(ack, "R7 late wp ignored", int'(ack), 1);
    bus_stop();
    wp = 1'b0;
    tick(2);
    check(cap_n == base_cap + 2, "R7 bytes stored", cap_n, base_cap + 2);
    check(commit_n == base_commit + 1, "R6 commit after late wp", commit_n, base_commit + 1);
    check(cap_addr[base_cap + 1] == 17'h01241, "R4 address with a16 clear",
          int'(cap_addr[base_cap + 1]), 17'h01241);

    check(hi_change_n == 0, "R10 pull change while SCL high", hi_change_n, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule